// File: doc/BRIEF.md
# Carry-Save Population Count Tree

This block counts the set bits of an input vector and returns the count as a binary number. No chain of incrementers is used. The vector is reduced by a tree of full adders, each acting as a (3,2) counter. Seven-input (7,3) counters form the leaves. Small four-input counters or short multi-bit adders merge the partial results.

Two widths are supported: 16 and 30 input bits. Each gives a 5-bit count, sized from the width. Setting `PIPELINE` to zero makes the whole path combinational. Any other value places registers after the leaf level and after the middle level. A valid flag travels with the data through those registers.

The block suits error counting in a receiver. The incoming word is XORed with an expected pattern, and the count of the result gives the number of differing bits.

Top module: `popc_tree`

## Requirements
- R1: With WIDTH=16, out_count equals the number of ones in in_bits[15:0], as an unsigned 5-bit value.
- R2: With WIDTH=30, out_count equals the number of ones in in_bits[29:0], as an unsigned 5-bit value.
- R3: When out_valid is high, out_count never exceeds WIDTH. An all-ones input gives exactly WIDTH: 5'b10000 for 16 and 5'b11110 for 30.
- R4: With PIPELINE=0, out_count follows in_bits in the same cycle with no clock edge involved, and out_valid equals in_valid.
- R5: With PIPELINE nonzero, the count of a vector sampled at a rising edge together with in_valid appears on out_count after the second following rising edge, with out_valid high. Back-to-back vectors stream at one per cycle.
- R6: With PIPELINE nonzero, a synchronous active-high rst holds out_valid low while it is asserted, even when in_valid is high. out_valid stays low until two edges after a valid vector is sampled with rst low.
- R7: With PIPELINE nonzero, a vector sampled with in_valid low yields out_valid low two edges later.
- R8: Every one-hot input vector gives a count of 1, whatever the position of the set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline registers |
| rst | input | 1 | Synchronous active-high reset, clears the valid pipeline |
| in_valid | input | 1 | Marks in_bits as carrying a vector to count |
| in_bits | input | WIDTH | Vector whose set bits are counted |
| out_valid | output | 1 | Marks out_count as holding a result |
| out_count | output | $clog2(WIDTH+1) | Number of ones in the corresponding input vector |

## Verification
The bench builds four copies of the block at the same time. It uses WIDTH 16 and 30, each once with PIPELINE=0 and once with PIPELINE=1.

The two combinational copies show that the count appears in the same cycle. The two pipelined copies show the two-edge latency, the streaming behaviour, and the effect of reset and idle cycles on the valid flag.

Having both widths exercises both tree shapes. The 16-bit tree merges two (7,3) counters through four-input counters and a full adder. The 30-bit tree uses four (7,3) counters and short adders. The all-ones, all-zeros and walking-one vectors reach the extreme and per-position cases of each shape.

// File: rtl/popc_pkg.sv
package popc_pkg;
  // three-bit partial count produced by a (7,3) or 4-input counter
  typedef logic [2:0] cnt3_t;

  // width of a binary count able to hold 0..n
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/popc_fa.sv
// Full adder used as a (3,2) counter: three bits of equal weight in,
// a weight-1 sum and a weight-2 carry out.
module popc_fa (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ c;
  assign co = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/popc_c4.sv
// Four equal-weight bits reduced to a count 0..4.
module popc_c4 (
  input  logic [3:0]     bits,
  output popc_pkg::cnt3_t cnt
);
  logic s3, c3, k;

  popc_fa u_fa (.a(bits[0]), .b(bits[1]), .c(bits[2]), .s(s3), .co(c3));

  // fold in the fourth bit: both c3 and k carry weight 2
  assign k      = s3 & bits[3];
  assign cnt[0] = s3 ^ bits[3];
  assign cnt[1] = c3 ^ k;
  assign cnt[2] = c3 & k;
endmodule

// File: rtl/popc_c7.sv
// (7,3) counter built from four full adders.
module popc_c7 (
  input  logic [6:0]      bits,
  output popc_pkg::cnt3_t cnt
);
  logic s_lo, c_lo, s_hi, c_hi, c_mid;

  popc_fa u_lo  (.a(bits[0]), .b(bits[1]), .c(bits[2]), .s(s_lo),   .co(c_lo));
  popc_fa u_hi  (.a(bits[3]), .b(bits[4]), .c(bits[5]), .s(s_hi),   .co(c_hi));
  // weight-1 column: two sums plus the seventh input
  popc_fa u_one (.a(s_lo),    .b(s_hi),    .c(bits[6]), .s(cnt[0]), .co(c_mid));
  // weight-2 column: three carries
  popc_fa u_two (.a(c_lo),    .b(c_hi),    .c(c_mid),   .s(cnt[1]), .co(cnt[2]));
endmodule

// File: rtl/popc_pipe.sv
// Optional level register with a travelling valid flag.
module popc_pipe #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  input  logic         v_d,
  output logic [W-1:0] q,
  output logic         v_q
);
  if (EN) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
        q   <= '0;
      end else begin
        v_q <= v_d;
        q   <= d;
      end
    end

    AST_PIPE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (v_q == $past(v_d))); // R5
    AST_PIPE_RESET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !v_q); // R6
  end else begin : g_wire
    assign q   = d;
    assign v_q = v_d;
  end
endmodule

// File: rtl/popc_tree.sv
// Population count tree. WIDTH must be 16 or 30.
module popc_tree #(
  parameter int WIDTH    = 30,
  parameter int PIPELINE = 1,
  localparam int CNT_W   = popc_pkg::count_width(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_bits,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_count
);
  import popc_pkg::*;

  localparam bit REG_EN = (PIPELINE != 0);
  localparam int N_LEAF = WIDTH / 7;   // (7,3) counters at the leaves
  localparam int N_REST = WIDTH - 7 * N_LEAF;
  localparam int LEAF_W = 3 * N_LEAF + N_REST;

  logic v_leaf, v_mid;

  // ---------------- leaf level: (7,3) counters ----------------
  logic [LEAF_W-1:0] leaf_d, leaf_q;

  for (genvar g = 0; g < N_LEAF; g++) begin : g_leaf
    cnt3_t c;
    popc_c7 u_c7 (.bits(in_bits[7*g +: 7]), .cnt(c));
    assign leaf_d[3*g +: 3] = c;
  end
  assign leaf_d[LEAF_W-1 -: N_REST] = in_bits[WIDTH-1 -: N_REST];

  popc_pipe #(.W(LEAF_W), .EN(REG_EN)) u_p_leaf (
    .clk(clk), .rst(rst), .d(leaf_d), .v_d(in_valid), .q(leaf_q), .v_q(v_leaf));

  if (WIDTH == 16) begin : g_w16
    // leaf_q: [2:0] counter A, [5:3] counter B, [7:6] leftover bits
    cnt3_t lo4, hi4;
    logic  s1, c1;
    logic [5:0] mid_d, mid_q;

    // weight 1: A0, B0 and both leftover bits
    popc_c4 u_w0 (.bits({leaf_q[7], leaf_q[6], leaf_q[3], leaf_q[0]}), .cnt(lo4));
    // weight 2: A1, B1 and the weight-2 output of the first 4-counter
    popc_fa u_w1 (.a(leaf_q[1]), .b(leaf_q[4]), .c(lo4[1]), .s(s1), .co(c1));

    assign mid_d = {lo4[2], c1, leaf_q[5], leaf_q[2], s1, lo4[0]};

    popc_pipe #(.W(6), .EN(REG_EN)) u_p_mid (
      .clk(clk), .rst(rst), .d(mid_d), .v_d(v_leaf), .q(mid_q), .v_q(v_mid));

    // weight 4: A2, B2 and two weight-4 carries
    popc_c4 u_w2 (.bits(mid_q[5:2]), .cnt(hi4));
    assign out_count = {hi4, mid_q[1], mid_q[0]};
  end else if (WIDTH == 30) begin : g_w30
    // leaf_q: four 3-bit counts then two leftover bits
    logic [3:0] pair0, pair1;
    logic [1:0] rest;
    logic [9:0] mid_d, mid_q;

    assign pair0 = {1'b0, leaf_q[2:0]} + {1'b0, leaf_q[5:3]};
    assign pair1 = {1'b0, leaf_q[8:6]} + {1'b0, leaf_q[11:9]};
    assign rest  = {leaf_q[12] & leaf_q[13], leaf_q[12] ^ leaf_q[13]};
    assign mid_d = {rest, pair1, pair0};

    popc_pipe #(.W(10), .EN(REG_EN)) u_p_mid (
      .clk(clk), .rst(rst), .d(mid_d), .v_d(v_leaf), .q(mid_q), .v_q(v_mid));

    assign out_count = {1'b0, mid_q[3:0]} + {1'b0, mid_q[7:4]}
                     + {3'b000, mid_q[9:8]};
  end

  assign out_valid = v_mid;

  // ---------------- assertions ----------------
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_count) <= WIDTH)); // R3

  if (REG_EN) begin : g_chk_pipe
    AST_PIPE_EXACT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(out_count) == $countones($past(in_bits, 2)))); // R5
    AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (out_valid == $past(in_valid, 2))); // R7
  end else begin : g_chk_comb
    AST_COMB_EXACT: assert property (@(posedge clk) disable iff (rst)
      int'(out_count) == $countones(in_bits)); // R4
  end
endmodule

// File: tb/test_popc_tree.sv
module test_popc_tree;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] b16 = '0;
  logic [29:0] b30 = '0;

  logic       v16p, v30p, v16c, v30c;
  logic [4:0] c16p, c30p, c16c, c30c;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  popc_tree #(.WIDTH(16), .PIPELINE(1)) i_popc_tree_w16p (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(b16),
    .out_valid(v16p), .out_count(c16p));
  popc_tree #(.WIDTH(30), .PIPELINE(1)) i_popc_tree (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(b30),
    .out_valid(v30p), .out_count(c30p));
  popc_tree #(.WIDTH(16), .PIPELINE(0)) i_popc_tree_w16c (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(b16),
    .out_valid(v16c), .out_count(c16c));
  popc_tree #(.WIDTH(30), .PIPELINE(0)) i_popc_tree_w30c (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(b30),
    .out_valid(v30c), .out_count(c30c));

  function automatic int ones(input logic [29:0] x);
    int n = 0;
    for (int i = 0; i < 30; i++) n += int'(x[i]);
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // history of the two previous steps for the pipelined copies
  logic [15:0] h16_1 = '0, h16_2 = '0;
  logic [29:0] h30_1 = '0, h30_2 = '0;
  logic        hv_1 = 1'b0, hv_2 = 1'b0;
  string       hp_1 = "", hp_2 = "";

  task automatic step(input logic [15:0] x16, input logic [29:0] x30,
                      input logic v, input string ph);
    @(negedge clk);
    // pipelined outputs now reflect the vector driven two steps ago
    chk(hv_2 ? "R5 valid w16 pipelined" : "R7 idle valid w16 pipelined", int'(v16p), int'(hv_2));
    chk(hv_2 ? "R5 valid w30 pipelined" : "R7 idle valid w30 pipelined", int'(v30p), int'(hv_2));
    if (hv_2) begin
      chk({"R1 R5 ", hp_2, " w16 pipelined"}, int'(c16p), ones({14'b0, h16_2}));
      chk({"R2 R5 ", hp_2, " w30 pipelined"}, int'(c30p), ones(h30_2));
    end
    h16_2 = h16_1; h30_2 = h30_1; hv_2 = hv_1; hp_2 = hp_1;
    h16_1 = x16;   h30_1 = x30;   hv_1 = v;    hp_1 = ph;
    b16 = x16; b30 = x30; in_valid = v;
    #5;
    chk("R4 valid w16 comb", int'(v16c), int'(v));
    chk("R4 valid w30 comb", int'(v30c), int'(v));
    chk({"R1 R4 ", ph, " w16 comb"}, int'(c16c), ones({14'b0, x16}));
    chk({"R2 R4 ", ph, " w30 comb"}, int'(c30c), ones(x30));
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    // reset with valid data presented: reset must win (R6)
    rst = 1'b1; in_valid = 1'b1; b16 = '1; b30 = '1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 reset valid w16 pipelined", int'(v16p), 0);
      chk("R6 reset valid w30 pipelined", int'(v30p), 0);
    end
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0; b16 = '0; b30 = '0;

    // directed corners
    step('0, '0, 1'b1, "zeros");
    step('1, '1, 1'b1, "R3 all-ones");
    step('1, '1, 1'b1, "R3 all-ones");
    for (int i = 0; i < 30; i++)
      step(16'(1) << (i % 16), 30'(1) << i, 1'b1, "R8 one-hot");
    step(16'h5555, 30'h2AAA_AAAA, 1'b1, "alternating");
    step(16'hAAAA, 30'h1555_5555, 1'b1, "alternating");
    step('1, '1, 1'b0, "R7 idle");
    step('0, '0, 1'b0, "R7 idle");
    step('1, '1, 1'b1, "R3 all-ones");

    // constrained random: mostly valid, varied densities
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r1, r2;
      r1 = $urandom();
      r2 = $urandom();
      if (i % 4 == 1) begin r1 = r1 | $urandom(); r2 = r2 | $urandom(); end
      if (i % 4 == 2) begin r1 = r1 & $urandom(); r2 = r2 & $urandom(); end
      step(r1[15:0], r2[29:0], ($urandom_range(0, 3) != 0), "random");
    end

    // flush the pipeline
    step('0, '0, 1'b0, "flush");
    step('0, '0, 1'b0, "flush");
    step('0, '0, 1'b0, "flush");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule